// File: doc/BRIEF.md
# Word Shifter with Status Flags

This block is the shift unit of a 16-bit minicomputer-style processor datapath. Each cycle it takes an operand word, a two-bit operation code, the four-bit count field of the shift instruction and the low four bits of register zero. It returns the shifted word and an updated copy of the processor status word, both registered, one clock after the inputs are presented.

Four operations are supported: arithmetic shift left, arithmetic shift right, logical shift right and rotate right. A count field of zero makes the unit take the amount from register zero instead. The unit rewrites only the five status bits that a shift defines: logical greater, arithmetic greater, equal, carry and overflow. Every other status bit, the odd-parity bit among them, leaves the unit exactly as it came in. Overflow on a left shift records a sign change at any step of the shift, not just at the last one.

Top module: `word_shifter`

## Requirements
- R1: With op = 2'b00 (arithmetic left) the result is the operand shifted left by the shift amount, with zeros entering from bit 0.
- R2: With op = 2'b01 (arithmetic right) the result is the operand shifted right by the shift amount, with copies of the operand's bit 15 entering from the top.
- R3: With op = 2'b10 (logical right) the result is the operand shifted right by the shift amount, with zeros entering from the top.
- R4: With op = 2'b11 (rotate right) each bit leaving bit 0 re-enters at bit 15, so a shift amount of 16 returns the operand unchanged.
- R5: The shift amount is the count field when that field is nonzero. When the field is zero, the amount is the low four bits of register zero, and a value of zero there means 16.
- R6: Carry (status bit 12) is the last bit shifted out of the word. For rotate right it equals bit 15 of the result.
- R7: Overflow (status bit 11) is set by arithmetic left when bit 15 takes a value different from the operand's bit 15 after any single step of the shift. Overflow is cleared by the other three operations.
- R8: Logical greater (status bit 15) is set when the result is nonzero. Arithmetic greater (bit 14) is set when the result is nonzero and its bit 15 is clear. Equal (bit 13) is set when the result is zero.
- R9: Status bits 10 down to 0 pass from the status input to the status output unchanged. Bit 10 is the odd-parity bit.
- R10: Outputs appear one clock after their inputs. While reset is asserted, the result and the status output are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation: 00 arith left, 01 arith right, 10 logical right, 11 rotate right |
| cnt_field_i | input | 4 | Count field from the instruction; zero selects register zero |
| r0_low_i | input | 4 | Low four bits of register zero |
| operand_i | input | 16 | Word to shift |
| status_i | input | 16 | Incoming status word |
| result_o | output | 16 | Shifted word, registered |
| status_o | output | 16 | Updated status word, registered |

## Verification
The assertions assume that op, count, register-zero bits, operand and status inputs are driven with known values on every clock edge after reset, because each property relates an output to the inputs seen one edge earlier. The bench changes inputs only on the falling edge and holds every input at a defined value from the first edge. Random operands, counts and status words cover the whole input space, so nothing has to be excluded. The directed part goes through the six operand words that cover sign, zero and alternating-bit cases, each with the flags preset both ways.

// File: rtl/word_shifter_pkg.sv
package word_shifter_pkg;

    localparam int WORD_W = 16;
    localparam int CNT_W  = 4;
    localparam int AMT_W  = CNT_W + 1;

    localparam int ST_LGT = 15;
    localparam int ST_AGT = 14;
    localparam int ST_EQ  = 13;
    localparam int ST_C   = 12;
    localparam int ST_OV  = 11;
    localparam int ST_OP  = 10;

    typedef enum logic [1:0] {
        SH_ALEFT  = 2'b00,
        SH_ARIGHT = 2'b01,
        SH_LRIGHT = 2'b10,
        SH_ROTR   = 2'b11
    } shift_op_e;

    typedef struct packed {
        logic [WORD_W-1:0] result;
        logic [WORD_W-1:0] status;
    } shifter_out_t;

endpackage

// File: rtl/shift_amount_sel.sv
module shift_amount_sel #(
    parameter int CNT_W = 4,
    localparam int AMT_W = CNT_W + 1
) (
    input  logic [CNT_W-1:0] field_i,
    input  logic [CNT_W-1:0] reg_i,
    output logic [AMT_W-1:0] amount_o
);
    localparam logic [AMT_W-1:0] FULL = AMT_W'(1 << CNT_W);

    always_comb begin
        if (field_i != '0) begin
            amount_o = {1'b0, field_i};
        end else if (reg_i != '0) begin
            amount_o = {1'b0, reg_i};
        end else begin
            amount_o = FULL;
        end
    end
endmodule

// File: rtl/shift_core.sv
module shift_core
    import word_shifter_pkg::*;
#(
    parameter int W = 16,
    localparam int AW = $clog2(W) + 1
) (
    input  logic [1:0]    op_i,
    input  logic [W-1:0]  data_i,
    input  logic [AW-1:0] amount_i,
    output logic [W-1:0]  data_o,
    output logic          carry_o,
    output logic          ovf_o
);
    logic [2*W-1:0] wide_left;
    logic [2*W-1:0] wide_sra;
    logic [2*W-1:0] wide_srl;
    logic [2*W-1:0] wide_rot;
    logic [W-1:0]   msb_diff;
    logic           sign;

    assign sign = data_i[W-1];

    // msb_diff[k-1]: the bit that lands in the top position after k steps
    // differs from the original sign
    genvar k;
    generate
        for (k = 1; k <= W; k++) begin : g_step
            if (k < W) begin : g_in
                assign msb_diff[k-1] = (data_i[W-1-k] != sign) && (amount_i >= AW'(k));
            end else begin : g_last
                assign msb_diff[k-1] = sign && (amount_i >= AW'(k));
            end
        end
    endgenerate

    always_comb begin
        wide_left = {{W{1'b0}}, data_i} << amount_i;
        wide_sra  = $unsigned($signed({data_i, {W{1'b0}}}) >>> amount_i);
        wide_srl  = {data_i, {W{1'b0}}} >> amount_i;
        wide_rot  = {data_i, data_i} >> amount_i;
        data_o  = '0;
        carry_o = 1'b0;
        ovf_o   = 1'b0;
        unique case (shift_op_e'(op_i))
            SH_ALEFT: begin
                data_o  = wide_left[W-1:0];
                carry_o = wide_left[W];
                ovf_o   = |msb_diff;
            end
            SH_ARIGHT: begin
                data_o  = wide_sra[2*W-1:W];
                carry_o = wide_sra[W-1];
            end
            SH_LRIGHT: begin
                data_o  = wide_srl[2*W-1:W];
                carry_o = wide_srl[W-1];
            end
            SH_ROTR: begin
                data_o  = wide_rot[W-1:0];
                carry_o = wide_rot[W-1];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/status_update.sv
module status_update
    import word_shifter_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] result_i,
    input  logic         carry_i,
    input  logic         ovf_i,
    input  logic [W-1:0] status_i,
    output logic [W-1:0] status_o
);
    logic zero;
    assign zero = (result_i == '0);

    always_comb begin
        status_o         = status_i;
        status_o[ST_LGT] = !zero;
        status_o[ST_AGT] = !zero && !result_i[W-1];
        status_o[ST_EQ]  = zero;
        status_o[ST_C]   = carry_i;
        status_o[ST_OV]  = ovf_i;
    end
endmodule

// File: rtl/word_shifter.sv
module word_shifter
    import word_shifter_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_i,
    input  logic [CNT_W-1:0]  cnt_field_i,
    input  logic [CNT_W-1:0]  r0_low_i,
    input  logic [WORD_W-1:0] operand_i,
    input  logic [WORD_W-1:0] status_i,
    output logic [WORD_W-1:0] result_o,
    output logic [WORD_W-1:0] status_o
);
    logic [AMT_W-1:0]  amount;
    logic [WORD_W-1:0] shifted;
    logic              carry;
    logic              ovf;
    logic [WORD_W-1:0] status_new;
    shifter_out_t      out_d;
    shifter_out_t      out_q;

    shift_amount_sel #(.CNT_W(CNT_W)) i_amount (
        .field_i  (cnt_field_i),
        .reg_i    (r0_low_i),
        .amount_o (amount)
    );

    shift_core #(.W(WORD_W)) i_core (
        .op_i     (op_i),
        .data_i   (operand_i),
        .amount_i (amount),
        .data_o   (shifted),
        .carry_o  (carry),
        .ovf_o    (ovf)
    );

    status_update #(.W(WORD_W)) i_status (
        .result_i (shifted),
        .carry_i  (carry),
        .ovf_i    (ovf),
        .status_i (status_i),
        .status_o (status_new)
    );

    always_comb begin
        out_d        = out_q;
        out_d.result = shifted;
        out_d.status = status_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o = out_q.result;
    assign status_o = out_q.status;
endmodule

// File: rtl/word_shifter_chk.sv
module word_shifter_chk
    import word_shifter_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        op_i,
    input logic [CNT_W-1:0]  cnt_field_i,
    input logic [WORD_W-1:0] operand_i,
    input logic [WORD_W-1:0] status_i,
    input logic [WORD_W-1:0] result_o,
    input logic [WORD_W-1:0] status_o
);
    logic seen_edge;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_edge <= 1'b0;
        else        seen_edge <= 1'b1;
    end

    // R9
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge |-> status_o[ST_OP:0] == $past(status_i[ST_OP:0]));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && $past(op_i) != SH_ALEFT) |-> !status_o[ST_OV]);

    // R8
    zero_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge |-> ($countones({status_o[ST_LGT], status_o[ST_EQ]}) == 1
                       && (!status_o[ST_AGT] || status_o[ST_LGT])));

    // R4
    rotate_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && $past(op_i) == SH_ROTR)
        |-> ($countones(result_o) == $countones($past(operand_i))));

    // R6
    rotate_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && $past(op_i) == SH_ROTR) |-> status_o[ST_C] == result_o[WORD_W-1]);

    // R3
    logical_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && $past(op_i) == SH_LRIGHT && $past(cnt_field_i) != '0)
        |-> !result_o[WORD_W-1]);

    // R2
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && $past(op_i) == SH_ARIGHT)
        |-> result_o[WORD_W-1] == $past(operand_i[WORD_W-1]));

    // R10
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |-> (result_o == '0 && status_o == '0));
endmodule

bind word_shifter word_shifter_chk i_word_shifter_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .cnt_field_i (cnt_field_i),
    .operand_i   (operand_i),
    .status_i    (status_i),
    .result_o    (result_o),
    .status_o    (status_o)
);

// File: tb/test_word_shifter.sv
module test_word_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_i = '0;
    logic [3:0]  cnt_field_i = '0;
    logic [3:0]  r0_low_i = '0;
    logic [15:0] operand_i = '0;
    logic [15:0] status_i = '0;
    logic [15:0] result_o;
    logic [15:0] status_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    word_shifter i_word_shifter (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .cnt_field_i(cnt_field_i),
        .r0_low_i(r0_low_i), .operand_i(operand_i), .status_i(status_i),
        .result_o(result_o), .status_o(status_o)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // reference model: one bit per step
    function automatic void model(input logic [1:0] op, input logic [3:0] fld,
                                  input logic [3:0] r0, input logic [15:0] a,
                                  input logic [15:0] st_in,
                                  output logic [15:0] res, output logic [15:0] st);
        int n;
        logic c, v, s0;
        n = (fld != 0) ? int'(fld) : ((r0 != 0) ? int'(r0) : 16);
        res = a; c = 1'b0; v = 1'b0; s0 = a[15];
        for (int i = 0; i < n; i++) begin
            case (op)
                2'b00: begin c = res[15]; res = {res[14:0], 1'b0}; if (res[15] != s0) v = 1'b1; end
                2'b01: begin c = res[0]; res = {res[15], res[15:1]}; end
                2'b10: begin c = res[0]; res = {1'b0, res[15:1]}; end
                default: begin c = res[0]; res = {res[0], res[15:1]}; end
            endcase
        end
        st = st_in;
        st[15] = (res != 0);
        st[14] = (res != 0) && !res[15];
        st[13] = (res == 0);
        st[12] = c;
        st[11] = v;
    endfunction

    task automatic run_one(input logic [1:0] op, input logic [3:0] fld, input logic [3:0] r0,
                           input logic [15:0] a, input logic [15:0] st);
        logic [15:0] er, es;
        string rtag;
        model(op, fld, r0, a, st, er, es);
        @(negedge clk);
        op_i = op; cnt_field_i = fld; r0_low_i = r0; operand_i = a; status_i = st;
        @(negedge clk);
        case (op)
            2'b00: rtag = "R1";
            2'b01: rtag = "R2";
            2'b10: rtag = "R3";
            default: rtag = "R4";
        endcase
        if (fld == 0) rtag = {rtag, " R5"};
        check({rtag, " result"}, result_o, er);
        check("R6 carry", {15'b0, status_o[12]}, {15'b0, es[12]});
        check("R7 overflow", {15'b0, status_o[11]}, {15'b0, es[11]});
        check("R8 compare flags", {13'b0, status_o[15:13]}, {13'b0, es[15:13]});
        check("R9 other bits", {5'b0, status_o[10:0]}, {5'b0, es[10:0]});
    endtask

    initial begin
        logic [15:0] ops [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hAAAA, 16'hFFFF};
        logic [3:0] flds [5] = '{4'd1, 4'd4, 4'd15, 4'd0, 4'd0};
        logic [3:0] r0s  [5] = '{4'd9, 4'd0, 4'd2, 4'd0, 4'd3};
        void'($urandom(32'd1357));
        @(negedge clk);
        check("R10 reset result", result_o, 16'h0000);
        check("R10 reset status", status_o, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        for (int o = 0; o < 4; o++)
            for (int a = 0; a < 6; a++)
                for (int c = 0; c < 5; c++) begin
                    run_one(2'(o), flds[c], r0s[c], ops[a], 16'h0000);
                    run_one(2'(o), flds[c], r0s[c], ops[a], 16'hFFFF);
                    run_one(2'(o), flds[c], r0s[c], ops[a], 16'hF800);
                    run_one(2'(o), flds[c], r0s[c], ops[a], 16'h07FF);
                end
        for (int i = 0; i < 400; i++)
            run_one(2'($urandom), 4'($urandom), 4'($urandom), 16'($urandom), 16'($urandom));
        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 150000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule